// File: doc/BRIEF.md
# State-Dependent Phase Delay Timer

This block measures how long a traffic-light sequencer has spent in its current phase. It watches the sequencer's 4-bit state code, counts clock cycles in one shared accumulator, and compares that count with an interval limit chosen by the active state. When the count reaches the chosen limit, a done flag goes high. The sequencer reads the flag to decide when to move on.

The count restarts whenever the state code changes. It also stops at the limit and does not wrap. The sequencer can therefore hold a phase past its minimum length without the flag dropping. Amber phases use a short limit, the pedestrian walk and blink phases use their own limits, and every other code, including the unused codes, uses the largest 4-bit value. A synchronous clear input zeroes the count and forces the flag low.

Top module: `phase_delay_timer`

## Requirements
- R1: While `rst` is high, `elapsed` becomes 0 at each clock edge and `delay_done` is low.
- R2: While the state code is unchanged, and neither `clear` nor `rst` is high, `elapsed` rises by exactly one at each clock edge until it equals the selected limit.
- R3: State codes 3 and 8 (amber phases) select a limit of 2 cycles.
- R4: State code 5 (pedestrian walk) selects a limit of 10 cycles.
- R5: State code 6 (pedestrian blink) selects a limit of 5 cycles.
- R6: The remaining valid codes 0, 1, 2, 4, 7, 9 and 10 select the maximum limit of 15 cycles.
- R7: Unused state codes 11 to 15 select the maximum limit of 15 cycles.
- R8: `delay_done` is high exactly when the state code equals the code registered at the last edge, `clear` and `rst` are low, and `elapsed` equals the selected limit. Once the limit is reached, `elapsed` holds there.
- R9: In the cycle in which the state code differs from the code registered at the last edge, `delay_done` is low. At the next edge `elapsed` becomes 0.
- R10: While `clear` is high, `delay_done` is low, and at each clock edge `elapsed` becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous clear of the interval count |
| state_code | input | 4 | Current state code from the sequencer |
| elapsed | output | 4 | Cycles counted in the current phase |
| delay_done | output | 1 | Count has reached the limit of the active state |

## Verification
Each limit class is tested by holding a code from that class long enough to pass its limit. This shows that the correct limit was picked and that the count stops there rather than wrapping. An unused code is held the same way, to separate the maximum fallback from a wrong table entry. A state change in the middle of a count shows that the count restarts and that the flag drops in the same cycle. A change directly between two codes with different limits shows that the new limit is used. A clear applied part way through a count is checked separately from a state change, so that the two restart paths can be told apart.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  typedef enum logic [1:0] {
    KIND_LONG  = 2'd0,
    KIND_AMBER = 2'd1,
    KIND_WALK  = 2'd2,
    KIND_FLASH = 2'd3
  } lim_kind_e;

  function automatic lim_kind_e kind_of(input int code, input int num_states,
                                        input int amber_a, input int amber_b,
                                        input int walk_code, input int flash_code);
    lim_kind_e k;
    if (code >= num_states)                     k = KIND_LONG;
    else if (code == amber_a || code == amber_b) k = KIND_AMBER;
    else if (code == walk_code)                  k = KIND_WALK;
    else if (code == flash_code)                 k = KIND_FLASH;
    else                                         k = KIND_LONG;
    return k;
  endfunction
endpackage

// File: rtl/pdt_phase_track.sv
module pdt_phase_track #(
  parameter int STATE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STATE_W-1:0] state_i,
  output logic               changed
);
  logic [STATE_W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= state_i;
    else     prev_q <= state_i;
  end

  assign changed = (state_i != prev_q);
endmodule

// File: rtl/pdt_limit_sel.sv
module pdt_limit_sel #(
  parameter int STATE_W    = 4,
  parameter int CNT_W      = 4,
  parameter int NUM_STATES = 11,
  parameter int AMBER_A    = 3,
  parameter int AMBER_B    = 8,
  parameter int WALK_CODE  = 5,
  parameter int FLASH_CODE = 6,
  parameter int LIM_AMBER  = 2,
  parameter int LIM_WALK   = 10,
  parameter int LIM_FLASH  = 5,
  parameter int LIM_LONG   = 15
) (
  input  logic [STATE_W-1:0] state_i,
  output logic [CNT_W-1:0]   limit_o
);
  import pdt_pkg::*;
  localparam int NUM_CODES = 1 << STATE_W;

  logic [CNT_W-1:0] lim_tab [NUM_CODES];

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
    localparam lim_kind_e KIND =
      kind_of(g, NUM_STATES, AMBER_A, AMBER_B, WALK_CODE, FLASH_CODE);
    if (KIND == KIND_AMBER) begin : g_amb
      assign lim_tab[g] = CNT_W'(LIM_AMBER);
    end else if (KIND == KIND_WALK) begin : g_walk
      assign lim_tab[g] = CNT_W'(LIM_WALK);
    end else if (KIND == KIND_FLASH) begin : g_flash
      assign lim_tab[g] = CNT_W'(LIM_FLASH);
    end else begin : g_long
      assign lim_tab[g] = CNT_W'(LIM_LONG);
    end
  end

  assign limit_o = lim_tab[state_i];
endmodule

// File: rtl/pdt_accum.sv
module pdt_accum #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             restart,
  input  logic             at_limit,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || clr || restart) count_q <= '0;
    else if (!at_limit)        count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;

  // R2: one step per cycle below the limit
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr && !restart && !at_limit) |=> (count_q == $past(count_q) + 1'b1));
  // R8: the count stays at the limit
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!clr && !restart && at_limit) |=> $stable(count_q));
  // R9: the count restarts after a state change
  assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (restart && !clr) |=> (count_q == '0));
  // R10: clear zeroes the count
  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count_q == '0));
endmodule

// File: rtl/pdt_compare.sv
module pdt_compare #(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             equal_o
);
  assign equal_o = (count_i == limit_i);
endmodule

// File: rtl/phase_delay_timer.sv
module phase_delay_timer #(
  parameter int STATE_W    = 4,
  parameter int CNT_W      = 4,
  parameter int NUM_STATES = 11,
  parameter int AMBER_A    = 3,
  parameter int AMBER_B    = 8,
  parameter int WALK_CODE  = 5,
  parameter int FLASH_CODE = 6,
  parameter int LIM_AMBER  = 2,
  parameter int LIM_WALK   = 10,
  parameter int LIM_FLASH  = 5,
  parameter int LIM_LONG   = (1 << CNT_W) - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic [STATE_W-1:0] state_code,
  output logic [CNT_W-1:0]   elapsed,
  output logic               delay_done
);
  logic             changed;
  logic             equal;
  logic [CNT_W-1:0] sel_limit;
  logic [CNT_W-1:0] count;

  pdt_phase_track #(.STATE_W(STATE_W)) u_track (
    .clk(clk), .rst(rst), .state_i(state_code), .changed(changed)
  );

  pdt_limit_sel #(
    .STATE_W(STATE_W), .CNT_W(CNT_W), .NUM_STATES(NUM_STATES),
    .AMBER_A(AMBER_A), .AMBER_B(AMBER_B), .WALK_CODE(WALK_CODE),
    .FLASH_CODE(FLASH_CODE), .LIM_AMBER(LIM_AMBER), .LIM_WALK(LIM_WALK),
    .LIM_FLASH(LIM_FLASH), .LIM_LONG(LIM_LONG)
  ) u_sel (
    .state_i(state_code), .limit_o(sel_limit)
  );

  pdt_compare #(.CNT_W(CNT_W)) u_cmp (
    .count_i(count), .limit_i(sel_limit), .equal_o(equal)
  );

  pdt_accum #(.CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst(rst), .clr(clear), .restart(changed),
    .at_limit(equal), .count_o(count)
  );

  assign elapsed    = count;
  assign delay_done = equal && !changed && !clear && !rst;

  // R7: unused codes fall back to the longest limit
  assert_unused_long_R7: assert property (@(posedge clk) disable iff (rst)
    (state_code >= STATE_W'(NUM_STATES)) |-> (sel_limit == CNT_W'(LIM_LONG)));
  // R9: no done flag in the cycle of a state change
  assert_change_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    changed |-> !delay_done);
  // R8: the count never passes the active limit
  assert_bound_R8: assert property (@(posedge clk) disable iff (rst)
    (!changed && !clear) |-> (elapsed <= sel_limit));
  // R10: clear keeps the flag low
  assert_clear_flag_R10: assert property (@(posedge clk) disable iff (rst)
    clear |-> !delay_done);
endmodule

// File: tb/phase_delay_timer_test.sv
module phase_delay_timer_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [3:0] cnt;
    logic       flag;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clear = 1'b0;
  logic [3:0] state_code = 4'd0;
  logic [3:0] elapsed;
  logic       delay_done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  exp_t sb_q[$];

  logic [3:0] m_prev = 4'd0;
  logic [3:0] m_cnt = 4'd0;

  phase_delay_timer uut (
    .clk(clk), .rst(rst), .clear(clear), .state_code(state_code),
    .elapsed(elapsed), .delay_done(delay_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] lim_of(input logic [3:0] s);
    case (s)
      4'd3, 4'd8: return 4'd2;
      4'd5:       return 4'd10;
      4'd6:       return 4'd5;
      default:    return 4'd15;
    endcase
  endfunction

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic step(input logic [3:0] s, input logic c, input logic r, input string tag);
    exp_t e;
    logic chg;
    @(negedge clk);
    chg = (s != m_prev);
    state_code = s;
    clear = c;
    rst = r;
    if (chg && !r && !c) begin
      #1;
      checks++;
      if (delay_done !== 1'b0) begin
        failures++;
        $display("FAIL R9 flag in change cycle: actual=%b expected=0", delay_done);
      end
    end
    if (r || c || chg) m_cnt = 4'd0;
    else if (m_cnt != lim_of(s)) m_cnt = m_cnt + 4'd1;
    m_prev = s;
    e.cnt = m_cnt;
    e.flag = !r && !c && (m_cnt == lim_of(s));
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic hold(input logic [3:0] s, input int n, input string tag);
    for (int i = 0; i < n; i++) step(s, 1'b0, 1'b0, tag);
  endtask

  // monitor: compares just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (elapsed !== e.cnt || delay_done !== e.flag) begin
          failures++;
          $display("FAIL %s: actual elapsed=%0d done=%b expected elapsed=%0d done=%b",
                   e.tag, elapsed, delay_done, e.cnt, e.flag);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset
    step(4'd0, 1'b0, 1'b1, "R1 reset");
    step(4'd0, 1'b0, 1'b1, "R1 reset");
    // R2 and R6: code 0 counts to 15 and holds (R8)
    hold(4'd0, 20, "R2 R6 R8 long");
    // R3 amber, both codes
    hold(4'd3, 5, "R3 R8 amber3");
    hold(4'd8, 4, "R3 amber8");
    // R4 walk
    hold(4'd5, 13, "R4 R8 walk");
    // R5 blink, followed directly by a code with a different limit
    hold(4'd6, 8, "R5 R8 blink");
    hold(4'd4, 17, "R6 long4");
    hold(4'd10, 3, "R6 long10");
    // R7 unused codes
    hold(4'd12, 18, "R7 unused12");
    hold(4'd15, 17, "R7 unused15");
    // R9 change in mid count
    hold(4'd9, 4, "R9 pre");
    hold(4'd5, 11, "R9 restart");
    // R10 clear in mid count, then counting resumes
    hold(4'd1, 6, "R10 pre");
    step(4'd1, 1'b1, 1'b0, "R10 clear");
    step(4'd1, 1'b1, 1'b0, "R10 clear");
    hold(4'd1, 4, "R10 resume");
    // R10 clear while held at the limit
    hold(4'd3, 4, "R10 limit");
    step(4'd3, 1'b1, 1'b0, "R10 clear at limit");
    hold(4'd3, 3, "R10 after");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule